// File: doc/BRIEF.md
# QoS Round-Robin Switch Controller

This is the control half of a multiport router placed in a two-dimensional mesh that also has diagonal links. Each port interface raises a routing request when a head flit arrives. The request carries the destination router coordinates, the destination core slot and a QoS level. The controller does not move any flit data. Each cycle it does four things:

- works out, for every requester, the first free output in a turn-restricted candidate list;
- uses one arbiter to pick a single winner among the requesters that found a free output;
- records which input now owns that output;
- drives the select lines of the crossbar from those records on the following cycle.

An output stays owned until the tail flit of the packet passing through it is reported. The router's own coordinates and the assignment of its eight ports to link directions or local core slots are parameters fixed at elaboration.

Each port is given a direction code through the parameter `PORT_DIR`, four bits per port with port 0 in the least significant nibble. The codes are:

| Code | Meaning |
|------|---------|
| 0 | N |
| 1 | S |
| 2 | E |
| 3 | W |
| 4 | NE |
| 5 | NW |
| 6 | SE |
| 7 | SW |
| 8+k | local core slot k |
| 15 | unused |

The default map is port0 = core 0, port1 = N, port2 = E, port3 = S, port4 = W, port5 = NE, port6 = SE and port7 = NW. It has no SW port. The router sits at (2,2). A smaller y lies to the north and a larger x lies to the east.

Top module: `qos_switch_ctrl`

## Requirements
- R1: At most one bit of `grant` is set in any cycle.
- R2: Among eligible requests, the one with the numerically highest `req_qos` is granted.
- R3: Ties at the best QoS level are broken round-robin. The search starts at the input just after the previous winner and wraps from input 7 back to input 0. After reset the search starts at input 0.
- R4: A request takes part in arbitration only if one of its candidate ports is present and not busy. A request with no such port stays pending, gets no grant, and does not block a lower-QoS request that is eligible.
- R5: A request granted in cycle t shows in cycle t+1 as the requester's `grant` bit, as the chosen output's `out_busy` bit, and as `xbar_src` of that output equal to the requester's index.
- R6: An output stays busy and keeps its `xbar_src` until `out_tail` is raised for it. The output reads free in the cycle after that.
- R7: Candidates are tried left to right, and a port that is absent or busy is skipped. The lists by offset (dx, dy) from the router are:

  | Offset | Candidates |
  |--------|------------|
  | dx>0, dy=0 | E, N, S |
  | dx<0, dy=0 | W |
  | dx=0, dy>0 | S, W, E |
  | dx=0, dy<0 | N, W, E |
  | dx<0, dy<0 | NW, W |
  | dx<0, dy>0 | SW, W |
  | dx>0, dy<0 | NE, E, N |
  | dx>0, dy>0 | SE, E, S |

- R8: A diagonal port is never chosen when the destination shares the router's row or column, even when the diagonal is free. When both offsets are nonzero the diagonal is tried first. If the diagonal port is absent, the next candidate is used.
- R9: While `rst` is high, and in the first cycle after it, `grant` and `out_busy` are all zero.
- R10: A destination equal to the router's own coordinates routes to the port coded 8+`req_core`. If no port has that code, the request is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORT | Pending head-flit routing request, one per input |
| req_dst_x | input | NPORT*COORD_W | Destination router x, one per input |
| req_dst_y | input | NPORT*COORD_W | Destination router y, one per input |
| req_core | input | NPORT*CORE_W | Destination local core slot, one per input |
| req_qos | input | NPORT*QOS_W | QoS level (higher wins), one per input |
| out_tail | input | NPORT | Tail flit leaving this output in this cycle |
| grant | output | NPORT | Registered one-hot grant to the winning input |
| out_busy | output | NPORT | Output owned by a packet; also the crossbar enable |
| xbar_src | output | NPORT*PSEL_W | Input index feeding each output |

## Verification
The assertions assume that a port interface drops `req_valid` in the cycle in which it sees its `grant` bit. They also assume that an input never requests while it already holds a connection, and that `out_tail` is raised only for an output that is busy. The bench keeps to all three. It clears each request on the falling edge right after the grant becomes visible, and it pulses a tail only on outputs it has just seen granted. The bench places concurrent requests on distinct free outputs, or deliberately on a busy one, so the order of grants depends only on QoS, eligibility and the round-robin pointer, and the pointer is followed from one test to the next.

// File: rtl/qos_switch_ctrl_pkg.sv
package qos_switch_ctrl_pkg;
  localparam int DIR_W = 4;
  localparam logic [DIR_W-1:0] DIR_N     = 4'd0;
  localparam logic [DIR_W-1:0] DIR_S     = 4'd1;
  localparam logic [DIR_W-1:0] DIR_E     = 4'd2;
  localparam logic [DIR_W-1:0] DIR_W_    = 4'd3;
  localparam logic [DIR_W-1:0] DIR_NE    = 4'd4;
  localparam logic [DIR_W-1:0] DIR_NW    = 4'd5;
  localparam logic [DIR_W-1:0] DIR_SE    = 4'd6;
  localparam logic [DIR_W-1:0] DIR_SW    = 4'd7;
  localparam logic [DIR_W-1:0] DIR_LOCAL = 4'd8;
  localparam logic [DIR_W-1:0] DIR_NONE  = 4'd15;
  localparam int NCAND = 3;

  typedef enum logic [3:0] {
    RG_HERE, RG_EAST, RG_WEST, RG_SOUTH, RG_NORTH,
    RG_NWEST, RG_SWEST, RG_NEAST, RG_SEAST
  } region_e;
endpackage

// File: rtl/qsc_route.sv
module qsc_route
  import qos_switch_ctrl_pkg::*;
#(
  parameter int NPORT   = 8,
  parameter int COORD_W = 3,
  parameter int CORE_W  = 2,
  parameter int PSEL_W  = 3,
  parameter int CUR_X   = 2,
  parameter int CUR_Y   = 2,
  parameter logic [NPORT*DIR_W-1:0] PORT_DIR = '0
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [CORE_W-1:0]  core,
  input  logic [NPORT-1:0]   busy,
  output logic               hit,
  output logic [PSEL_W-1:0]  port
);
  localparam logic [COORD_W-1:0] CX = COORD_W'(CUR_X);
  localparam logic [COORD_W-1:0] CY = COORD_W'(CUR_Y);

  region_e rg;
  logic [DIR_W-1:0] cand [NCAND];

  always_comb begin
    if (dst_x == CX)
      rg = (dst_y == CY) ? RG_HERE : ((dst_y > CY) ? RG_SOUTH : RG_NORTH);
    else if (dst_x > CX)
      rg = (dst_y == CY) ? RG_EAST : ((dst_y > CY) ? RG_SEAST : RG_NEAST);
    else
      rg = (dst_y == CY) ? RG_WEST : ((dst_y > CY) ? RG_SWEST : RG_NWEST);
  end

  always_comb begin
    cand[0] = DIR_NONE;
    cand[1] = DIR_NONE;
    cand[2] = DIR_NONE;
    unique case (rg)
      RG_HERE:  cand[0] = DIR_LOCAL + DIR_W'(core);
      RG_EAST:  begin cand[0] = DIR_E;  cand[1] = DIR_N;  cand[2] = DIR_S;  end
      RG_WEST:  cand[0] = DIR_W_;
      RG_SOUTH: begin cand[0] = DIR_S;  cand[1] = DIR_W_; cand[2] = DIR_E;  end
      RG_NORTH: begin cand[0] = DIR_N;  cand[1] = DIR_W_; cand[2] = DIR_E;  end
      RG_NWEST: begin cand[0] = DIR_NW; cand[1] = DIR_W_; end
      RG_SWEST: begin cand[0] = DIR_SW; cand[1] = DIR_W_; end
      RG_NEAST: begin cand[0] = DIR_NE; cand[1] = DIR_E;  cand[2] = DIR_N;  end
      RG_SEAST: begin cand[0] = DIR_SE; cand[1] = DIR_E;  cand[2] = DIR_S;  end
      default:  cand[0] = DIR_NONE;
    endcase
  end

  // Try candidates in order; for each, any free port carrying that code wins.
  always_comb begin
    hit  = 1'b0;
    port = '0;
    for (int c = 0; c < NCAND; c++) begin
      for (int p = 0; p < NPORT; p++) begin
        if (!hit && cand[c] != DIR_NONE &&
            PORT_DIR[p*DIR_W +: DIR_W] == cand[c] && !busy[p]) begin
          hit  = 1'b1;
          port = PSEL_W'(p);
        end
      end
    end
  end
endmodule

// File: rtl/qsc_arbiter.sv
module qsc_arbiter #(
  parameter int NPORT  = 8,
  parameter int QOS_W  = 2,
  parameter int PSEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORT-1:0]       elig,
  input  logic [NPORT*QOS_W-1:0] qos,
  output logic                   win_valid,
  output logic [PSEL_W-1:0]      win_idx
);
  localparam logic [PSEL_W-1:0] LAST = PSEL_W'(NPORT - 1);

  logic [PSEL_W-1:0] ptr_q;
  logic [QOS_W-1:0]  best;

  always_comb begin
    best = '0;
    for (int i = 0; i < NPORT; i++)
      if (elig[i] && qos[i*QOS_W +: QOS_W] > best) best = qos[i*QOS_W +: QOS_W];
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int k = 0; k < NPORT; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= NPORT) idx = idx - NPORT;
      if (!win_valid && elig[idx] && qos[idx*QOS_W +: QOS_W] == best) begin
        win_valid = 1'b1;
        win_idx   = PSEL_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ptr_q <= '0;
    else if (win_valid) ptr_q <= (win_idx == LAST) ? '0 : win_idx + 1'b1;
  end
endmodule

// File: rtl/qsc_outstate.sv
module qsc_outstate #(
  parameter int NPORT  = 8,
  parameter int PSEL_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    win_valid,
  input  logic [PSEL_W-1:0]       win_port,
  input  logic [PSEL_W-1:0]       win_src,
  input  logic [NPORT-1:0]        tail,
  output logic [NPORT-1:0]        busy,
  output logic [NPORT*PSEL_W-1:0] src
);
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        busy[o]                 <= 1'b0;
        src[o*PSEL_W +: PSEL_W] <= '0;
      end else if (tail[o]) begin
        busy[o] <= 1'b0;
      end else if (win_valid && win_port == PSEL_W'(o)) begin
        busy[o]                 <= 1'b1;
        src[o*PSEL_W +: PSEL_W] <= win_src;
      end
    end
  end
endmodule

// File: rtl/qos_switch_ctrl.sv
module qos_switch_ctrl
  import qos_switch_ctrl_pkg::*;
#(
  parameter int NPORT   = 8,
  parameter int COORD_W = 3,
  parameter int CORE_W  = 2,
  parameter int QOS_W   = 2,
  parameter int CUR_X   = 2,
  parameter int CUR_Y   = 2,
  parameter logic [NPORT*4-1:0] PORT_DIR = 32'h5643_1208,
  localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORT-1:0]         req_valid,
  input  logic [NPORT*COORD_W-1:0] req_dst_x,
  input  logic [NPORT*COORD_W-1:0] req_dst_y,
  input  logic [NPORT*CORE_W-1:0]  req_core,
  input  logic [NPORT*QOS_W-1:0]   req_qos,
  input  logic [NPORT-1:0]         out_tail,
  output logic [NPORT-1:0]         grant,
  output logic [NPORT-1:0]         out_busy,
  output logic [NPORT*PSEL_W-1:0]  xbar_src
);
  logic [NPORT-1:0]        hit;
  logic [NPORT*PSEL_W-1:0] rport;
  logic                    win_valid;
  logic [PSEL_W-1:0]       win_idx;
  logic [PSEL_W-1:0]       win_port;

  for (genvar i = 0; i < NPORT; i++) begin : g_rc
    qsc_route #(
      .NPORT(NPORT), .COORD_W(COORD_W), .CORE_W(CORE_W), .PSEL_W(PSEL_W),
      .CUR_X(CUR_X), .CUR_Y(CUR_Y), .PORT_DIR(PORT_DIR)
    ) u_rc (
      .dst_x (req_dst_x[i*COORD_W +: COORD_W]),
      .dst_y (req_dst_y[i*COORD_W +: COORD_W]),
      .core  (req_core[i*CORE_W +: CORE_W]),
      .busy  (out_busy),
      .hit   (hit[i]),
      .port  (rport[i*PSEL_W +: PSEL_W])
    );
  end

  qsc_arbiter #(.NPORT(NPORT), .QOS_W(QOS_W), .PSEL_W(PSEL_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .elig      (req_valid & hit),
    .qos       (req_qos),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  assign win_port = rport[win_idx*PSEL_W +: PSEL_W];

  qsc_outstate #(.NPORT(NPORT), .PSEL_W(PSEL_W)) u_ost (
    .clk       (clk),
    .rst       (rst),
    .win_valid (win_valid),
    .win_port  (win_port),
    .win_src   (win_idx),
    .tail      (out_tail),
    .busy      (out_busy),
    .src       (xbar_src)
  );

  always_ff @(posedge clk) begin
    if (rst)            grant <= '0;
    else if (win_valid) grant <= NPORT'(1) << win_idx;
    else                grant <= '0;
  end
endmodule

// File: rtl/qos_switch_ctrl_checker.sv
module qos_switch_ctrl_checker #(
  parameter int NPORT  = 8,
  parameter int PSEL_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPORT-1:0]        req_valid,
  input logic [NPORT-1:0]        out_tail,
  input logic [NPORT-1:0]        grant,
  input logic [NPORT-1:0]        out_busy,
  input logic [NPORT*PSEL_W-1:0] xbar_src
);
  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> $past(req_valid[i]));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    assert_claim_with_grant_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(out_busy[o]) |-> grant[xbar_src[o*PSEL_W +: PSEL_W]]);
    assert_hold_until_tail_R6: assert property (@(posedge clk) disable iff (rst)
      (out_busy[o] && !out_tail[o]) |=> (out_busy[o] && $stable(xbar_src[o*PSEL_W +: PSEL_W])));
    assert_tail_frees_R6: assert property (@(posedge clk) disable iff (rst)
      (out_busy[o] && out_tail[o]) |=> !out_busy[o]);
  end
endmodule

bind qos_switch_ctrl qos_switch_ctrl_checker #(.NPORT(NPORT), .PSEL_W(PSEL_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .out_tail(out_tail),
  .grant(grant), .out_busy(out_busy), .xbar_src(xbar_src)
);

// File: tb/qos_switch_ctrl_tb.sv
module qos_switch_ctrl_tb;
  localparam int N = 8;
  localparam int CW = 3;
  localparam int KW = 2;
  localparam int QW = 2;
  localparam int SW = 3;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N*CW-1:0] req_dst_x = '0;
  logic [N*CW-1:0] req_dst_y = '0;
  logic [N*KW-1:0] req_core  = '0;
  logic [N*QW-1:0] req_qos   = '0;
  logic [N-1:0]    out_tail  = '0;
  logic [N-1:0]    grant;
  logic [N-1:0]    out_busy;
  logic [N*SW-1:0] xbar_src;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #2.5 clk = ~clk;

  qos_switch_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst_x(req_dst_x),
    .req_dst_y(req_dst_y), .req_core(req_core), .req_qos(req_qos),
    .out_tail(out_tail), .grant(grant), .out_busy(out_busy), .xbar_src(xbar_src)
  );

  // {src, x, y, core, qos, expected output (15 = never granted)}; router at (2,2)
  localparam logic [16:0] VEC [NVEC] = '{
    {3'd1, 3'd2, 3'd2, 2'd0, 2'd0, 4'd0},   // R10 local core 0 -> port0
    {3'd0, 3'd3, 3'd2, 2'd0, 2'd1, 4'd2},   // R7 east -> E
    {3'd2, 3'd0, 3'd2, 2'd0, 2'd0, 4'd4},   // R7 west -> W
    {3'd4, 3'd2, 3'd4, 2'd0, 2'd2, 4'd3},   // R7 south -> S
    {3'd3, 3'd2, 3'd0, 2'd0, 2'd3, 4'd1},   // R7 north -> N
    {3'd6, 3'd0, 3'd0, 2'd0, 2'd0, 4'd7},   // R8 NW diagonal first
    {3'd5, 3'd0, 3'd4, 2'd0, 2'd1, 4'd4},   // R8 SW absent -> W
    {3'd7, 3'd4, 3'd0, 2'd0, 2'd0, 4'd5},   // R8 NE diagonal
    {3'd0, 3'd4, 3'd4, 2'd0, 2'd2, 4'd6},   // R8 SE diagonal
    {3'd3, 3'd2, 3'd2, 2'd1, 2'd0, 4'd15}   // R10 core slot 1 absent
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int i, input int x, input int y, input int k, input int q);
    req_dst_x[i*CW +: CW] = CW'(x);
    req_dst_y[i*CW +: CW] = CW'(y);
    req_core[i*KW +: KW]  = KW'(k);
    req_qos[i*QW +: QW]   = QW'(q);
    req_valid[i]          = 1'b1;
  endtask

  function automatic int src_of(input int o);
    return int'(xbar_src[o*SW +: SW]);
  endfunction

  // one request alone; checks grant and connection, then drops the request
  task automatic solo(input int i, input int x, input int y, input int q, input int o, input string tag);
    put(i, x, y, 0, q);
    step();
    chk(grant == N'(1 << i), tag, int'(grant), 1 << i);
    chk(out_busy[o] && src_of(o) == i, tag, src_of(o), i);
    req_valid[i] = 1'b0;
  endtask

  task automatic expect_grant(input int i, input int o, input string tag);
    step();
    chk(grant == N'(1 << i), tag, int'(grant), 1 << i);
    chk(src_of(o) == i, tag, src_of(o), i);
    req_valid[i] = 1'b0;
  endtask

  task automatic release_all();
    out_tail = out_busy;
    step();
    out_tail = '0;
    chk(out_busy == '0, "R6 release", int'(out_busy), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      $display("FAIL R1 watchdog actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk(grant == '0 && out_busy == '0, "R9 in reset", int'(out_busy), 0);
    rst = 1'b0;
    step();
    chk(grant == '0 && out_busy == '0, "R9 after reset", int'(grant), 0);

    // vector table: R5 R7 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      automatic int s = int'(VEC[v][16:14]);
      automatic int e = int'(VEC[v][3:0]);
      put(s, int'(VEC[v][13:11]), int'(VEC[v][10:8]), int'(VEC[v][7:6]), int'(VEC[v][5:4]));
      step();
      if (e != 15) begin
        chk(grant == N'(1 << s), $sformatf("R5 vec%0d grant", v), int'(grant), 1 << s);
        chk(out_busy == N'(1 << e), $sformatf("R7 vec%0d output", v), int'(out_busy), 1 << e);
        chk(src_of(e) == s, $sformatf("R8 vec%0d xbar_src", v), src_of(e), s);
        req_valid[s] = 1'b0;
        out_tail[e]  = 1'b1;
        step();
        out_tail = '0;
        chk(out_busy == '0, $sformatf("R6 vec%0d release", v), int'(out_busy), 0);
      end else begin
        step();
        chk(grant == '0 && out_busy == '0, $sformatf("R10 vec%0d no grant", v), int'(grant), 0);
        req_valid[s] = 1'b0;
      end
    end

    // adaptive fallback E -> N -> S, then pending (R4, R7, R8)
    solo(1, 4, 2, 0, 2, "R7 east to E");
    solo(2, 3, 2, 0, 1, "R8 E busy -> N not NE");
    solo(3, 4, 2, 0, 3, "R7 E,N busy -> S");
    put(5, 3, 2, 0, 3);
    step();
    chk(grant == '0, "R4 all candidates busy", int'(grant), 0);
    step();
    chk(grant == '0, "R4 still pending", int'(grant), 0);
    out_tail[3] = 1'b1;
    step();
    out_tail = '0;
    chk(grant == '0 && !out_busy[3], "R6 S freed after tail", int'(out_busy), 8'h06);
    expect_grant(5, 3, "R4 pending granted once S free");
    chk(out_busy == 8'h0E, "R6 others stay busy", int'(out_busy), 8'h0E);
    release_all();

    // ineligible high QoS must not block eligible low QoS (R4)
    solo(0, 0, 2, 0, 4, "R7 west to W");
    put(6, 0, 2, 0, 3);
    put(7, 2, 0, 0, 0);
    expect_grant(7, 1, "R4 eligible low qos wins");
    req_valid[6] = 1'b0;
    release_all();

    // QoS priority with pointer at 0 (R2)
    put(2, 2, 4, 0, 1);
    put(5, 2, 0, 0, 2);
    put(1, 0, 2, 0, 0);
    expect_grant(5, 1, "R2 qos2 first");
    expect_grant(2, 3, "R2 qos1 second");
    expect_grant(1, 4, "R2 qos0 last");
    release_all();

    // round robin, pointer now 2 (R3)
    put(1, 0, 2, 0, 1);
    put(4, 2, 0, 0, 1);
    put(6, 2, 4, 0, 1);
    expect_grant(4, 1, "R3 rr first");
    expect_grant(6, 3, "R3 rr second");
    expect_grant(1, 4, "R3 rr wrap");
    release_all();

    // reset clears held connections (R9)
    solo(0, 3, 2, 0, 2, "R5 before reset");
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(out_busy == '0 && grant == '0, "R9 mid-run reset", int'(out_busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule